// File: doc/BRIEF.md
# Battery Monitor Sleep-Mode Controller

This block decides when a battery-monitoring chip drops into its low-power state and when it returns to full operation. It watches the magnitude of the measured pack current against a programmable threshold. It also watches the two serial-bus lines (clock and data), a configuration bit that can forbid sleep, and a slow timebase tick that paces all of its timing.

Sleep begins only when three things hold at the same moment. The current must be under the threshold. Both bus lines must have stayed low for a full two-second interval, counted in ticks. The inhibit bit must be clear. While asleep, two independent schedules run. One raises a pulse that starts voltage, temperature and self-discharge processing. The other raises a pulse that starts a current measurement.

Two events end sleep. A current result above the threshold wakes the block, and so does a rising edge on either bus line. After waking, every entry condition must be met again from scratch, which includes a fresh bus-low interval.

Top module: `bms_sleep_ctrl`

## Requirements
- R1: After synchronous reset the block is awake: `sleeping` is 0 and neither `wake_vt` nor `wake_cur` pulses while awake.
- R2: Entry needs `cur_mag` strictly below `cur_thresh`. A current equal to or above the threshold keeps the block awake even when every other condition holds.
- R3: Entry needs both bus lines, seen through two-flop synchronizers, to stay low for IDLE_TICKS = TICK_HZ*IDLE_SEC consecutive ticks (8 with the defaults). A high sample on either line restarts this count from zero.
- R4: `sleep_inhibit` at 1 blocks entry. It models bit 4 of the miscellaneous configuration register, and only this bit matters.
- R5: While asleep, `wake_vt` pulses once every max(1, `vt_period`) ticks. Its count restarts at each entry, so the first pulse follows the vt_period-th tick after entry.
- R6: While asleep, `wake_cur` pulses once every max(1, `cur_period`) ticks. This schedule runs independently of R5 and restarts at each entry.
- R7: While asleep, a cycle with `cur_valid` at 1 and `cur_mag` strictly above `cur_thresh` returns the block to awake. A result equal to the threshold does not.
- R8: While asleep, a rising edge on either `bus_clk` or `bus_dat` returns the block to awake.
- R9: After any wake, re-entry needs a new complete bus-low interval of IDLE_TICKS ticks, even if the lines never went high.
- R10: `wake_vt` and `wake_cur` are registered single-cycle pulses, and they occur only when the block was asleep in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timebase strobe, one cycle wide |
| cur_mag | input | CUR_W | Latest absolute current magnitude |
| cur_valid | input | 1 | A new current measurement result is present on `cur_mag` |
| cur_thresh | input | CUR_W | Sleep current threshold |
| bus_clk | input | 1 | Serial-bus clock line level |
| bus_dat | input | 1 | Serial-bus data line level |
| sleep_inhibit | input | 1 | Configuration bit 4: 1 forbids sleep |
| vt_period | input | PER_W | Voltage/temperature wake period in ticks (0 means 1) |
| cur_period | input | PER_W | Current-measurement period in ticks (0 means 1) |
| sleeping | output | 1 | Registered sleep status |
| wake_vt | output | 1 | Voltage/temperature/self-discharge strobe |
| wake_cur | output | 1 | Current-measurement strobe |

## Verification
On every cycle the assertions check that strobes appear only after an asleep cycle, and that no cycle with the inhibit bit set or with current at or above the threshold leads into sleep. They also check that a valid over-threshold current reading always ends sleep on the next edge. What only the bench scenarios can show is timing over many ticks. This covers the exact count of strobes for each pair of periods, including period zero, and the separation of the two schedules. It also covers the restart of the bus-low count after a data-line blip and the need for a fresh full interval after a current-triggered wake.

// File: rtl/bms_sleep_pkg.sv
package bms_sleep_pkg;
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } slp_state_t;

  localparam int N_SCHED = 2;
  localparam int SCHED_VT  = 0;
  localparam int SCHED_CUR = 1;
endpackage

// File: rtl/bms_bus_idle_watch.sv
module bms_bus_idle_watch #(
  parameter int IDLE_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  output logic idle_met,
  output logic bus_rise
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_TICKS);

  logic [1:0]    sync_c, sync_d;
  logic          prev_c, prev_d;
  logic [CW-1:0] low_cnt;
  logic          any_high;

  // two-flop synchronizers plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_c <= '0;
      sync_d <= '0;
      prev_c <= 1'b0;
      prev_d <= 1'b0;
    end else begin
      sync_c <= {sync_c[0], bus_clk_i};
      sync_d <= {sync_d[0], bus_dat_i};
      prev_c <= sync_c[1];
      prev_d <= sync_d[1];
    end
  end

  assign any_high = sync_c[1] | sync_d[1];
  assign bus_rise = (sync_c[1] & ~prev_c) | (sync_d[1] & ~prev_d);

  // consecutive low ticks, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || restart || any_high) begin
      low_cnt <= '0;
    end else if (tick && (low_cnt != LIMIT)) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end

  assign idle_met = (low_cnt == LIMIT);
endmodule

// File: rtl/bms_period_strober.sv
module bms_period_strober #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             strobe
);
  logic [PER_W-1:0] cnt;
  logic [PER_W:0]   eff;
  logic [PER_W:0]   nxt;

  assign eff = (period == '0) ? (PER_W+1)'(1) : {1'b0, period};
  assign nxt = {1'b0, cnt} + (PER_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (tick) begin
        if (nxt >= eff) begin
          cnt    <= '0;
          strobe <= 1'b1;
        end else begin
          cnt <= nxt[PER_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bms_sleep_ctrl.sv
module bms_sleep_ctrl
  import bms_sleep_pkg::*;
#(
  parameter int CUR_W    = 16,
  parameter int PER_W    = 8,
  parameter int TICK_HZ  = 4,
  parameter int IDLE_SEC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CUR_W-1:0] cur_mag,
  input  logic             cur_valid,
  input  logic [CUR_W-1:0] cur_thresh,
  input  logic             bus_clk,
  input  logic             bus_dat,
  input  logic             sleep_inhibit,
  input  logic [PER_W-1:0] vt_period,
  input  logic [PER_W-1:0] cur_period,
  output logic             sleeping,
  output logic             wake_vt,
  output logic             wake_cur
);
  localparam int IDLE_TICKS = TICK_HZ * IDLE_SEC;

  slp_state_t state;
  logic idle_met, bus_rise;
  logic enter, leave, run;
  logic [N_SCHED-1:0][PER_W-1:0] periods;
  logic [N_SCHED-1:0]            strobes;

  bms_bus_idle_watch #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .restart  (leave),
    .bus_clk_i(bus_clk),
    .bus_dat_i(bus_dat),
    .idle_met (idle_met),
    .bus_rise (bus_rise)
  );

  always_comb begin
    enter = (state == ST_AWAKE) && idle_met && (cur_mag < cur_thresh) && !sleep_inhibit;
    leave = (state == ST_ASLEEP) && (bus_rise || (cur_valid && (cur_mag > cur_thresh)));
    run   = (state == ST_ASLEEP) && !leave;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_AWAKE;
    end else if (enter) begin
      state <= ST_ASLEEP;
    end else if (leave) begin
      state <= ST_AWAKE;
    end
  end

  assign sleeping = (state == ST_ASLEEP);

  assign periods[SCHED_VT]  = vt_period;
  assign periods[SCHED_CUR] = cur_period;

  for (genvar g = 0; g < N_SCHED; g++) begin : g_sched
    bms_period_strober #(.PER_W(PER_W)) u_strobe (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .run   (run),
      .period(periods[g]),
      .strobe(strobes[g])
    );
  end

  assign wake_vt  = strobes[SCHED_VT];
  assign wake_cur = strobes[SCHED_CUR];
endmodule

// File: rtl/bms_sleep_ctrl_chk.sv
module bms_sleep_ctrl_chk #(
  parameter int CUR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CUR_W-1:0] cur_mag,
  input logic             cur_valid,
  input logic [CUR_W-1:0] cur_thresh,
  input logic             sleep_inhibit,
  input logic             sleeping,
  input logic             wake_vt,
  input logic             wake_cur
);
  // R10
  vt_only_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake_vt |-> $past(sleeping));

  // R10
  cur_only_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake_cur |-> $past(sleeping));

  // R4
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && sleep_inhibit) |=> !sleeping);

  // R2
  high_current_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && (cur_mag >= cur_thresh)) |=> !sleeping);

  // R7
  current_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (sleeping && cur_valid && (cur_mag > cur_thresh)) |=> !sleeping);
endmodule

bind bms_sleep_ctrl bms_sleep_ctrl_chk #(.CUR_W(CUR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cur_mag      (cur_mag),
  .cur_valid    (cur_valid),
  .cur_thresh   (cur_thresh),
  .sleep_inhibit(sleep_inhibit),
  .sleeping     (sleeping),
  .wake_vt      (wake_vt),
  .wake_cur     (wake_cur)
);

// File: tb/bms_sleep_ctrl_test.sv
module bms_sleep_ctrl_test;
  localparam int CUR_W = 16;
  localparam int PER_W = 8;
  localparam int IDLE  = 8;
  localparam int NVEC  = 4;
  // vt_period, cur_period, ticks asleep, expected wake_vt, expected wake_cur
  localparam int VEC [NVEC][5] = '{
    '{3, 5, 15, 5, 3},
    '{0, 2,  4, 4, 2},
    '{1, 1,  3, 3, 3},
    '{4, 7, 20, 5, 2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [CUR_W-1:0] cur_mag = 16'd10;
  logic cur_valid = 1'b0;
  logic [CUR_W-1:0] cur_thresh = 16'd100;
  logic bus_clk = 1'b1;
  logic bus_dat = 1'b1;
  logic sleep_inhibit = 1'b0;
  logic [PER_W-1:0] vt_period = 8'd3;
  logic [PER_W-1:0] cur_period = 8'd5;
  logic sleeping, wake_vt, wake_cur;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_vt = 0;
  int cnt_cur = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bms_sleep_ctrl uut (
    .clk(clk), .rst(rst), .tick(tick), .cur_mag(cur_mag), .cur_valid(cur_valid),
    .cur_thresh(cur_thresh), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .sleep_inhibit(sleep_inhibit), .vt_period(vt_period), .cur_period(cur_period),
    .sleeping(sleeping), .wake_vt(wake_vt), .wake_cur(wake_cur)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (wake_vt)  cnt_vt  <= cnt_vt + 1;
    if (wake_cur) cnt_cur <= cnt_cur + 1;
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic bus_low();
    bus_clk = 1'b0;
    bus_dat = 1'b0;
    settle();
  endtask

  task automatic go_sleep();
    cur_mag = 16'd10;
    bus_low();
    tick_n(IDLE);
    settle();
  endtask

  task automatic wake_by_clk();
    bus_clk = 1'b1;
    settle();
    bus_clk = 1'b0;
    settle();
  endtask

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b_vt, b_cur;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk(sleeping, 0, "R1 sleeping after reset");
    b_vt = cnt_vt; b_cur = cnt_cur;
    tick_n(6);
    chk(cnt_vt - b_vt, 0, "R1 no wake_vt while awake");
    chk(cnt_cur - b_cur, 0, "R1 no wake_cur while awake");

    // table of schedules: R5, R6
    for (int v = 0; v < NVEC; v++) begin
      vt_period  = PER_W'(VEC[v][0]);
      cur_period = PER_W'(VEC[v][1]);
      go_sleep();
      chk(sleeping, 1, "R3 entry after full low interval");
      b_vt = cnt_vt; b_cur = cnt_cur;
      tick_n(VEC[v][2]);
      chk(cnt_vt - b_vt, VEC[v][3], "R5 wake_vt count");
      chk(cnt_cur - b_cur, VEC[v][4], "R6 wake_cur count");
      wake_by_clk();
      chk(sleeping, 0, "R8 clock rising edge wakes");
    end

    // R2: current equal to threshold blocks, then lower current enters
    cur_mag = 16'd100;
    bus_low();
    tick_n(IDLE + 2);
    chk(sleeping, 0, "R2 current at threshold blocks entry");
    cur_mag = 16'd10;
    settle();
    chk(sleeping, 1, "R2 current below threshold allows entry");
    wake_by_clk();

    // R4: inhibit bit blocks
    sleep_inhibit = 1'b1;
    tick_n(IDLE + 2);
    chk(sleeping, 0, "R4 inhibit blocks entry");
    sleep_inhibit = 1'b0;
    settle();
    chk(sleeping, 1, "R4 entry once inhibit cleared");
    wake_by_clk();

    // R3: boundary and restart on a data blip
    tick_n(IDLE - 1);
    chk(sleeping, 0, "R3 one tick short stays awake");
    @(negedge clk) bus_dat = 1'b1;
    @(negedge clk) bus_dat = 1'b0;
    settle();
    tick_n(IDLE - 1);
    chk(sleeping, 0, "R3 blip restarted the low count");
    tick_n(1);
    settle();
    chk(sleeping, 1, "R3 entry on final tick");

    // R7: equal result stays asleep, higher result wakes
    @(negedge clk) begin cur_mag = 16'd100; cur_valid = 1'b1; end
    @(negedge clk) cur_valid = 1'b0;
    settle();
    chk(sleeping, 1, "R7 result equal to threshold keeps sleep");
    @(negedge clk) begin cur_mag = 16'd150; cur_valid = 1'b1; end
    @(negedge clk) begin cur_valid = 1'b0; cur_mag = 16'd10; end
    settle();
    chk(sleeping, 0, "R7 result above threshold wakes");

    // R9: lines stayed low, yet a fresh full interval is needed
    tick_n(IDLE - 1);
    chk(sleeping, 0, "R9 no re-entry before fresh interval");
    tick_n(1);
    settle();
    chk(sleeping, 1, "R9 re-entry after fresh interval");

    // R8: data line rising edge wakes
    bus_dat = 1'b1;
    settle();
    chk(sleeping, 0, "R8 data rising edge wakes");
    bus_dat = 1'b0;
    settle();

    // R10: awake strobes stay silent
    b_vt = cnt_vt; b_cur = cnt_cur;
    vt_period = 8'd1;
    tick_n(3);
    chk(cnt_vt - b_vt, 0, "R10 no strobe while awake");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule